// File: doc/BRIEF.md
# Current-Limit Hiccup Restart Integrator

This block decides when a switching converter that keeps hitting its cycle-by-cycle current limit must be shut down and restarted. Once per switching cycle, marked by a strobe, it moves a saturating accumulator. A cycle that saw a current-limit event adds a large up step. A clean cycle takes away a small down step. The recommended steps are 6 and 1, a 6:1 ratio that models a capacitor charged by a strong source and bled by a weak sink. So a sustained overload builds up quickly, while rare and isolated limit events decay away.

When the accumulator reaches a programmable threshold (the level that stands for 1.0 V on the analog integrator), the block raises a sticky hiccup request. The power sequencer uses it to soft-stop the converter at six times the soft-start charge rate, wait out the restart delay, and then acknowledge. The acknowledge clears both the accumulator and the request. A disable input removes hiccup protection entirely. Cycle-by-cycle limiting is elsewhere and keeps working. The accumulator still integrates while disabled.

Top module: `hiccup_integrator`

## Requirements
- R1: While rst_ni is low, and on the first cycle after reset, acc_o is 0 and hiccup_req_o is 0.
- R2: With cyc_stb_i low and restart_ack_i low, acc_o keeps its value on the next clock.
- R3: With cyc_stb_i high, ilim_i high and restart_ack_i low, acc_o increases by up_step_i on the next clock, as long as the sum fits in ACC_W bits.
- R4: An up step whose sum exceeds 2^ACC_W-1 leaves acc_o at 2^ACC_W-1. The accumulator never wraps.
- R5: With cyc_stb_i high, ilim_i low and restart_ack_i low, acc_o decreases by dn_step_i on the next clock, and stops at 0 without wrapping below it.
- R6: When acc_o is at or above thresh_i and hic_dis_i is low, hiccup_req_o is high on the next clock. It then stays high until restart_ack_i or hic_dis_i is asserted.
- R7: While hic_dis_i is high, hiccup_req_o is low on the next clock, and acc_o still follows R2 to R5.
- R8: restart_ack_i high clears acc_o and hiccup_req_o to 0 on the next clock. This takes priority over any strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_stb_i | input | 1 | One-cycle pulse per switching cycle |
| ilim_i | input | 1 | Current limit hit during this switching cycle |
| hic_dis_i | input | 1 | Suppresses hiccup requests |
| restart_ack_i | input | 1 | Restart finished; clears accumulator and request |
| up_step_i | input | STEP_W | Step added on a limited cycle (recommended 6) |
| dn_step_i | input | STEP_W | Step removed on a clean cycle (recommended 1) |
| thresh_i | input | ACC_W | Accumulator level that triggers a hiccup |
| hiccup_req_o | output | 1 | Sticky hiccup request |
| acc_o | output | ACC_W | Accumulator value |

## Verification
The bench keeps the default ACC_W of 8 and STEP_W of 4, so the top of the accumulator sits at 255 and can be reached within a few dozen strobes.

It uses the 6 and 1 steps with a low threshold for the random phase. It then switches to an up step of 13 with threshold 255, which forces sums that are not exact multiples to clip at the top. A down step of 5 on clean cycles brings values that are not multiples of 5 onto the zero floor.

Disable and acknowledge pulses are mixed in at random, including together with strobes.

// File: rtl/hic_pkg.sv
package hic_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_CLR  = 2'd3
  } step_e;
endpackage

// File: rtl/hic_step_unit.sv
module hic_step_unit
  import hic_pkg::*;
#(
  parameter int ACC_W  = 8,
  parameter int STEP_W = 4
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [STEP_W-1:0] up_i,
  input  logic [STEP_W-1:0] dn_i,
  input  logic              stb_i,
  input  logic              ilim_i,
  input  logic              clr_i,
  output logic [ACC_W-1:0]  acc_nxt_o
);
  localparam int SUM_W = ACC_W + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  step_e            sel;
  logic [SUM_W-1:0] up_sum;
  logic [SUM_W-1:0] dn_dif;

  always_comb begin
    if (clr_i)       sel = STEP_CLR;
    else if (!stb_i) sel = STEP_HOLD;
    else if (ilim_i) sel = STEP_UP;
    else             sel = STEP_DN;
  end

  assign up_sum = {1'b0, acc_i} + {{(SUM_W-STEP_W){1'b0}}, up_i};
  assign dn_dif = {1'b0, acc_i} - {{(SUM_W-STEP_W){1'b0}}, dn_i};

  always_comb begin
    unique case (sel)
      STEP_CLR:  acc_nxt_o = '0;
      STEP_UP:   acc_nxt_o = up_sum[ACC_W] ? ACC_MAX : up_sum[ACC_W-1:0];
      // borrow into the top bit means the result went below zero
      STEP_DN:   acc_nxt_o = dn_dif[ACC_W] ? '0 : dn_dif[ACC_W-1:0];
      default:   acc_nxt_o = acc_i;
    endcase
  end
endmodule

// File: rtl/hic_thresh_cmp.sv
module hic_thresh_cmp #(
  parameter int ACC_W = 8
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] thresh_i,
  output logic             hit_o
);
  assign hit_o = (acc_i >= thresh_i);
endmodule

// File: rtl/hic_req_latch.sv
module hic_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic dis_i,
  input  logic clr_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             req_q <= 1'b0;
    else if (clr_i || dis_i) req_q <= 1'b0;
    else if (hit_i)          req_q <= 1'b1;
  end

  assign req_o = req_q;
endmodule

// File: rtl/hiccup_integrator.sv
module hiccup_integrator #(
  parameter int ACC_W  = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_stb_i,
  input  logic              ilim_i,
  input  logic              hic_dis_i,
  input  logic              restart_ack_i,
  input  logic [STEP_W-1:0] up_step_i,
  input  logic [STEP_W-1:0] dn_step_i,
  input  logic [ACC_W-1:0]  thresh_i,
  output logic              hiccup_req_o,
  output logic [ACC_W-1:0]  acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nxt;
  logic             hit;

  hic_step_unit #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_step (
    .acc_i    (acc_q),
    .up_i     (up_step_i),
    .dn_i     (dn_step_i),
    .stb_i    (cyc_stb_i),
    .ilim_i   (ilim_i),
    .clr_i    (restart_ack_i),
    .acc_nxt_o(acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_nxt;
  end

  hic_thresh_cmp #(.ACC_W(ACC_W)) u_cmp (
    .acc_i   (acc_q),
    .thresh_i(thresh_i),
    .hit_o   (hit)
  );

  hic_req_latch u_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit),
    .dis_i (hic_dis_i),
    .clr_i (restart_ack_i),
    .req_o (hiccup_req_o)
  );

  assign acc_o = acc_q;
endmodule

// File: rtl/hiccup_integrator_chk.sv
module hiccup_integrator_chk #(
  parameter int ACC_W  = 8,
  parameter int STEP_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_stb_i,
  input logic              ilim_i,
  input logic              hic_dis_i,
  input logic              restart_ack_i,
  input logic [STEP_W-1:0] up_step_i,
  input logic [STEP_W-1:0] dn_step_i,
  input logic [ACC_W-1:0]  thresh_i,
  input logic              hiccup_req_o,
  input logic [ACC_W-1:0]  acc_o
);
  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |=> (acc_o == '0));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_stb_i && !restart_ack_i) |=> $stable(acc_o));

  a_r3_up_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_stb_i && ilim_i && !restart_ack_i) |=> (acc_o >= $past(acc_o)));

  a_r5_dn_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_stb_i && !ilim_i && !restart_ack_i) |=> (acc_o <= $past(acc_o)));

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hiccup_req_o && !restart_ack_i && !hic_dis_i) |=> hiccup_req_o);

  a_r6_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc_o >= thresh_i) && !restart_ack_i && !hic_dis_i) |=> hiccup_req_o);

  a_r7_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hic_dis_i |=> !hiccup_req_o);

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_ack_i |=> (acc_o == '0 && !hiccup_req_o));
endmodule

bind hiccup_integrator hiccup_integrator_chk #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_chk (.*);

// File: tb/hiccup_integrator_tb_top.sv
module hiccup_integrator_tb_top;
  localparam int ACC_W  = 8;
  localparam int STEP_W = 4;
  localparam int MAXV   = (1 << ACC_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              stb = 1'b0, ilim = 1'b0, dis = 1'b0, ack = 1'b0;
  logic [STEP_W-1:0] up = 4'd6, dn = 4'd1;
  logic [ACC_W-1:0]  th = 8'd30;
  logic              req;
  logic [ACC_W-1:0]  acc;

  int checks = 0;
  int errors = 0;
  int exp_acc = 0;
  bit exp_req = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hiccup_integrator #(.ACC_W(ACC_W), .STEP_W(STEP_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_stb_i(stb), .ilim_i(ilim),
    .hic_dis_i(dis), .restart_ack_i(ack), .up_step_i(up), .dn_step_i(dn),
    .thresh_i(th), .hiccup_req_o(req), .acc_o(acc)
  );

  function automatic int next_acc(int a, bit s, bit l, bit c, int u, int d);
    if (c) return 0;
    if (!s) return a;
    if (l) return (a + u > MAXV) ? MAXV : a + u;
    return (a - d < 0) ? 0 : a - d;
  endfunction

  function automatic bit next_req(bit r, int a, int t, bit di, bit c);
    if (c || di) return 1'b0;
    return r || (a >= t);
  endfunction

  task automatic check(string tag, int act_acc, bit act_req);
    checks++;
    if (act_acc != exp_acc || act_req != exp_req) begin
      errors++;
      $display("FAIL %s acc=%0d req=%0b expected acc=%0d req=%0b",
               tag, act_acc, act_req, exp_acc, exp_req);
    end
  endtask

  // drive one cycle at negedge, update model, check at following negedge
  task automatic step(bit s, bit l, bit di, bit c);
    string tag;
    stb = s; ilim = l; dis = di; ack = c;
    if (c)                                         tag = "R8";
    else if (di)                                   tag = "R7";
    else if (s && l && exp_acc + int'(up) > MAXV)  tag = "R4";
    else if (s && l)                               tag = "R3";
    else if (s)                                    tag = "R5";
    else                                           tag = "R2";
    if (!c && !di && exp_acc >= int'(th)) tag = {tag, "/R6"};
    exp_req = next_req(exp_req, exp_acc, int'(th), di, c);
    exp_acc = next_acc(exp_acc, s, l, c, int'(up), int'(dn));
    @(negedge clk);
    check(tag, int'(acc), req);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", int'(acc), req);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(acc), req);

    // directed: build to threshold with 6/1 steps, then acknowledge
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0);

    // random 6/1 operation
    for (int i = 0; i < 2000; i++)
      step(($urandom % 3) != 0, ($urandom % 4) == 0,
           ($urandom % 16) == 0, ($urandom % 40) == 0);

    // saturation at the top
    up = 4'd13; th = 8'd255;
    for (int i = 0; i < 25; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 1500; i++)
      step(1'b1, ($urandom % 4) != 0, ($urandom % 20) == 0, ($urandom % 60) == 0);

    // floor at zero with a coarse down step
    dn = 4'd5; up = 4'd3; th = 8'd200;
    step(1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0);

    // disable held while accumulator is above threshold
    up = 4'd15; th = 8'd40; dn = 4'd1;
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 1000; i++)
      step(($urandom % 2) != 0, ($urandom % 3) == 0,
           ($urandom % 8) == 0, ($urandom % 50) == 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog acc=%0d req=%0b expected completion", acc, req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule